// File: doc/BRIEF.md
# Ethernet Address Lookup Table Engine

This block is the destination-address lookup stage of a small three-port Ethernet switch. It keeps a table of typed entries. Each entry carries a 48-bit MAC address and, depending on the address's group bit, either a single destination port with a block flag or a multicast port mask. Software fills and inspects the table indirectly: it stages an entry in three 32-bit data words and moves it with a single write to a table-control register. A direct write to the table is not possible.

For each received frame the switch pulses `lk_start` with the destination MAC and the ingress port. The engine scans the table one entry per clock and stops at the first address-type entry whose MAC matches. It then pulses `lk_done` with a forwarding port mask. A match resolves to a unicast port or to a multicast mask. A miss floods to every port except the ingress port. The result is then restricted to the ports whose state register says forwarding. A control register holds the engine enable, a self-clearing table-wipe bit and a VLAN-aware mode bit. The VLAN-aware bit is stored and read back only; it does not change the lookup.

Top module: `ale_lookup_engine`

## Requirements
- R1: Register word 1 is table control. A write with bit 31 set stores the staged entry into the table at the index in its low bits. A write with bit 31 clear loads that entry into the data words. The data words are at word addresses 2, 3 and 4. Address 2 holds entry bits 64 and up in its low bits, address 3 holds bits 63:32 and address 4 holds bits 31:0. Table control reads back the last index written.
- R2: Entry bits 61:60 are the type: 0 free, 1 address, 2 VLAN, 3 VLAN plus address. Only types 1 and 3 take part in a lookup. Their bits 47:0 are compared with the destination MAC, and the first address byte sits in bits 47:40.
- R3: When several entries match, the one with the lowest index decides the result.
- R4: An entry with bit 40 clear is unicast. If bit 65 (blocked) is clear, it forwards to the port numbered by bits 67:66. If bit 65 is set, or the port number is not below the port count, the mask is empty.
- R5: An entry with bit 40 set is multicast, and its port mask is taken from bit 66 upward: bit 66 is port 0, bit 67 port 1, bit 68 port 2.
- R6: A lookup that matches nothing floods to all ports except the ingress port.
- R7: Port p has a 2-bit state at word address 8+p: 0 disabled, 1 blocking, 2 learning, 3 forwarding. Every result is ANDed with the set of ports in state 3.
- R8: Control register (word address 0): bit 31 enables the engine and bit 2 selects VLAN-aware mode; both read back. Writing bit 30 as 1 wipes every entry to zero (free) and reads back as 0. While the engine is disabled, a lookup returns all forwarding ports.
- R9: `lk_done` is a one-cycle pulse. For a first match at index k it arrives k+1 clocks after the clock that samples `lk_start`. For a miss it arrives ENTRIES clocks after, and for a disabled engine 1 clock after. `lk_busy` is high in between, and a start pulse during that time is ignored.
- R10: After reset the control register and all port states read 0, every entry reads back as all zeros, and `lk_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_start | input | 1 | Start a lookup (accepted when not busy) |
| lk_mac | input | 48 | Destination MAC address |
| lk_ingress | input | 2 | Port the frame arrived on |
| lk_busy | output | 1 | A lookup is in progress |
| lk_done | output | 1 | One-cycle pulse: lk_mask is valid |
| lk_mask | output | NUM_PORTS | Forwarding port mask |

## Verification
The bench builds the engine with NUM_PORTS=3 and ENTRIES=8. The port count matches the entry layout, in which the three-bit multicast mask runs one bit past the 68-bit common part. The short table puts a full miss scan, the last index and the first-match ordering among shadowed entries within a few clocks, so exact latencies can be checked. Randomised rounds fill all eight entries with MACs from a four-address pool. This makes repeated, blocked, free and VLAN-only entries collide with the looked-up addresses under random port states.

// File: rtl/ale_pkg.sv
package ale_pkg;
   // entry field positions
   localparam int F_TYPE_LO  = 60;
   localparam int F_GROUP    = 40;
   localparam int F_BLOCKED  = 65;
   localparam int F_PORT_LO  = 66;
   localparam int F_MASK_LO  = 66;
   localparam int ENTRY_BASE = 68;

   // control / table-control bit positions
   localparam int C_ENABLE = 31;
   localparam int C_WIPE   = 30;
   localparam int C_VLAN   = 2;
   localparam int T_STORE  = 31;

   // register word addresses
   localparam logic [3:0] RA_CTRL = 4'd0;
   localparam logic [3:0] RA_TCTL = 4'd1;
   localparam logic [3:0] RA_DW0  = 4'd2;
   localparam logic [3:0] RA_DW1  = 4'd3;
   localparam logic [3:0] RA_DW2  = 4'd4;
   localparam logic [3:0] RA_PS0  = 4'd8;

   localparam logic [1:0] ET_FREE  = 2'd0;
   localparam logic [1:0] ET_ADDR  = 2'd1;
   localparam logic [1:0] ET_VLAN  = 2'd2;
   localparam logic [1:0] ET_VADDR = 2'd3;

   localparam logic [1:0] PS_FWD = 2'd3;

   typedef enum logic {SR_IDLE, SR_SCAN} srch_state_t;
endpackage

// File: rtl/ale_table.sv
module ale_table #(
   parameter int ENTRIES = 64,
   parameter int ENTRY_W = 69,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wipe,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   sw_idx,
   output logic [ENTRY_W-1:0] sw_rd,
   input  logic [IDX_W-1:0]   scan_idx,
   output logic [ENTRY_W-1:0] scan_rd
);
   logic [ENTRY_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (wipe) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign sw_rd   = mem[sw_idx];
   assign scan_rd = mem[scan_idx];

   // R8
   wipe_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wipe) |-> (mem[ENTRIES-1] == '0 && mem[0] == '0));

   // R1
   store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && !wipe) |-> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ale_regs.sv
module ale_regs
   import ale_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ENTRIES   = 64,
   parameter int ENTRY_W   = 69,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int UPW      = ENTRY_W - 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [3:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [ENTRY_W-1:0]   tbl_rd,
   output logic [IDX_W-1:0]     tbl_idx,
   output logic                 tbl_store,
   output logic [ENTRY_W-1:0]   tbl_wdata,
   output logic                 wipe,
   output logic                 eng_en,
   output logic [NUM_PORTS-1:0] fwd_ports
);
   logic              en_q, vlan_q;
   logic [IDX_W-1:0]  idx_q;
   logic [UPW-1:0]    dw0_q;
   logic [31:0]       dw1_q, dw2_q;
   logic [1:0]        pst_q [NUM_PORTS];
   logic              tctl_wr, tbl_load;
   logic              unused_wbits;

   assign tctl_wr   = reg_we && reg_addr == RA_TCTL;
   assign tbl_store = tctl_wr && reg_wdata[T_STORE];
   assign tbl_load  = tctl_wr && !reg_wdata[T_STORE];
   assign tbl_idx   = reg_wdata[IDX_W-1:0];
   assign tbl_wdata = {dw0_q, dw1_q, dw2_q};
   assign wipe      = reg_we && reg_addr == RA_CTRL && reg_wdata[C_WIPE];
   assign eng_en    = en_q;
   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         vlan_q <= 1'b0;
         idx_q  <= '0;
         dw0_q  <= '0;
         dw1_q  <= '0;
         dw2_q  <= '0;
         for (int p = 0; p < NUM_PORTS; p++) pst_q[p] <= 2'd0;
      end else begin
         if (reg_we) begin
            case (reg_addr)
               RA_CTRL: begin
                  en_q   <= reg_wdata[C_ENABLE];
                  vlan_q <= reg_wdata[C_VLAN];
               end
               RA_TCTL: idx_q <= reg_wdata[IDX_W-1:0];
               RA_DW0:  dw0_q <= reg_wdata[UPW-1:0];
               RA_DW1:  dw1_q <= reg_wdata;
               RA_DW2:  dw2_q <= reg_wdata;
               default: ;
            endcase
            for (int p = 0; p < NUM_PORTS; p++)
               if (reg_addr == 4'(RA_PS0 + p)) pst_q[p] <= reg_wdata[1:0];
         end
         if (tbl_load) begin
            dw0_q <= tbl_rd[ENTRY_W-1:64];
            dw1_q <= tbl_rd[63:32];
            dw2_q <= tbl_rd[31:0];
         end
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fwd
      assign fwd_ports[p] = (pst_q[p] == PS_FWD);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[C_ENABLE] = en_q;
            reg_rdata[C_VLAN]   = vlan_q;
         end
         RA_TCTL: reg_rdata = 32'(idx_q);
         RA_DW0:  reg_rdata = 32'(dw0_q);
         RA_DW1:  reg_rdata = dw1_q;
         RA_DW2:  reg_rdata = dw2_q;
         default: ;
      endcase
      for (int p = 0; p < NUM_PORTS; p++)
         if (reg_addr == 4'(RA_PS0 + p)) reg_rdata = 32'(pst_q[p]);
   end

   // R1
   load_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tbl_load) |-> (dw2_q == $past(tbl_rd[31:0]) && dw1_q == $past(tbl_rd[63:32])));
endmodule

// File: rtl/ale_search.sv
module ale_search
   import ale_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ENTRIES   = 64,
   parameter int ENTRY_W   = 69,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [47:0]          mac,
   input  logic [1:0]           ingress,
   input  logic                 eng_en,
   input  logic [NUM_PORTS-1:0] fwd_ports,
   input  logic [ENTRY_W-1:0]   scan_rd,
   output logic [IDX_W-1:0]     scan_idx,
   output logic                 busy,
   output logic                 done,
   output logic [NUM_PORTS-1:0] mask
);
   srch_state_t          st_q;
   logic [IDX_W-1:0]     idx_q;
   logic [47:0]          mac_q;
   logic [1:0]           ing_q;
   logic                 miss_q;
   logic                 is_addr, hit, last;
   logic [1:0]           typ;
   logic [NUM_PORTS-1:0] hit_mask, flood_mask, uc_mask;
   logic                 unused_ent;

   assign unused_ent = ^scan_rd;
   assign typ     = scan_rd[F_TYPE_LO +: 2];
   assign is_addr = (typ == ET_ADDR) || (typ == ET_VADDR);
   assign hit     = is_addr && (scan_rd[47:0] == mac_q);
   assign last    = (idx_q == IDX_W'(ENTRIES - 1));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign uc_mask[p]    = !scan_rd[F_BLOCKED] && (scan_rd[F_PORT_LO +: 2] == 2'(p));
      assign flood_mask[p] = (ing_q != 2'(p));
   end

   assign hit_mask = scan_rd[F_GROUP] ? scan_rd[F_MASK_LO +: NUM_PORTS] : uc_mask;
   assign scan_idx = idx_q;
   assign busy     = (st_q == SR_SCAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SR_IDLE;
         idx_q  <= '0;
         mac_q  <= '0;
         ing_q  <= '0;
         miss_q <= 1'b0;
         done   <= 1'b0;
         mask   <= '0;
      end else begin
         done <= 1'b0;
         case (st_q)
            SR_IDLE: if (start) begin
               mac_q <= mac;
               ing_q <= ingress;
               idx_q <= '0;
               st_q  <= SR_SCAN;
            end
            SR_SCAN: begin
               if (!eng_en) begin
                  mask   <= fwd_ports;
                  miss_q <= 1'b0;
                  done   <= 1'b1;
                  st_q   <= SR_IDLE;
               end else if (hit) begin
                  mask   <= hit_mask & fwd_ports;
                  miss_q <= 1'b0;
                  done   <= 1'b1;
                  st_q   <= SR_IDLE;
               end else if (last) begin
                  mask   <= flood_mask & fwd_ports;
                  miss_q <= 1'b1;
                  done   <= 1'b1;
                  st_q   <= SR_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= SR_IDLE;
         endcase
      end
   end

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   flood_no_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && miss_q && ing_q < 2'(NUM_PORTS)) |-> !mask[ing_q]);

   // R7
   mask_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((mask & ~$past(fwd_ports)) == '0));
endmodule

// File: rtl/ale_lookup_engine.sv
module ale_lookup_engine
   import ale_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ENTRIES   = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [3:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 lk_start,
   input  logic [47:0]          lk_mac,
   input  logic [1:0]           lk_ingress,
   output logic                 lk_busy,
   output logic                 lk_done,
   output logic [NUM_PORTS-1:0] lk_mask
);
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int ENTRY_W = (F_MASK_LO + NUM_PORTS > ENTRY_BASE) ? F_MASK_LO + NUM_PORTS : ENTRY_BASE;

   if (NUM_PORTS < 2 || NUM_PORTS > 4) begin : g_bad_ports
      $error("NUM_PORTS must be 2..4 (port number field is 2 bits)");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end

   logic [IDX_W-1:0]     tbl_idx, scan_idx;
   logic                 tbl_store, wipe, eng_en;
   logic [ENTRY_W-1:0]   tbl_wdata, sw_rd, scan_rd;
   logic [NUM_PORTS-1:0] fwd_ports;

   ale_regs #(.NUM_PORTS(NUM_PORTS), .ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_rd(sw_rd),
      .tbl_idx(tbl_idx), .tbl_store(tbl_store), .tbl_wdata(tbl_wdata),
      .wipe(wipe), .eng_en(eng_en), .fwd_ports(fwd_ports)
   );

   ale_table #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wipe(wipe), .wr_en(tbl_store),
      .wr_idx(tbl_idx), .wr_data(tbl_wdata), .sw_idx(tbl_idx), .sw_rd(sw_rd),
      .scan_idx(scan_idx), .scan_rd(scan_rd)
   );

   ale_search #(.NUM_PORTS(NUM_PORTS), .ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_search (
      .clk(clk), .rst_n(rst_n), .start(lk_start), .mac(lk_mac),
      .ingress(lk_ingress), .eng_en(eng_en), .fwd_ports(fwd_ports),
      .scan_rd(scan_rd), .scan_idx(scan_idx), .busy(lk_busy),
      .done(lk_done), .mask(lk_mask)
   );
endmodule

// File: tb/sim_ale_lookup_engine.sv
module sim_ale_lookup_engine;
   localparam int NP = 3;
   localparam int NE = 8;
   localparam int EW = 69;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_start = 1'b0;
   logic [47:0] lk_mac = '0;
   logic [1:0]  lk_ingress = '0;
   logic        lk_busy, lk_done;
   logic [NP-1:0] lk_mask;

   int checks = 0;
   int failures = 0;

   logic [EW-1:0] m_ent [NE];
   logic [1:0]    m_ps  [NP];
   logic          m_en;

   always #10 clk = ~clk;

   ale_lookup_engine #(.NUM_PORTS(NP), .ENTRIES(NE)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_start(lk_start),
      .lk_mac(lk_mac), .lk_ingress(lk_ingress), .lk_busy(lk_busy),
      .lk_done(lk_done), .lk_mask(lk_mask)
   );

   task automatic check(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_entry(input int idx, input logic [EW-1:0] e);
      wr(4'd2, 32'(e[EW-1:64]));
      wr(4'd3, e[63:32]);
      wr(4'd4, e[31:0]);
      wr(4'd1, 32'h8000_0000 | 32'(idx));
      m_ent[idx] = e;
   endtask

   task automatic get_entry(input int idx, output logic [EW-1:0] e);
      logic [31:0] w0, w1, w2;
      wr(4'd1, 32'(idx));
      rd(4'd2, w0); rd(4'd3, w1); rd(4'd4, w2);
      e = {w0[EW-65:0], w1, w2};
   endtask

   task automatic set_ps(input int p, input logic [1:0] s);
      wr(4'(8 + p), 32'(s));
      m_ps[p] = s;
   endtask

   task automatic do_lookup(input logic [47:0] mac, input logic [1:0] ing,
                            output logic [NP-1:0] m, output int cnt);
      @(negedge clk);
      lk_mac = mac; lk_ingress = ing; lk_start = 1'b1;
      @(negedge clk);
      lk_start = 1'b0;
      cnt = 0;
      while (!lk_done && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      m = lk_mask;
   endtask

   function automatic logic [EW-1:0] mk_uc(input logic [1:0] typ, input logic [47:0] mac,
                                           input logic [1:0] port, input logic blk);
      logic [EW-1:0] e = '0;
      e[61:60] = typ; e[47:0] = mac; e[67:66] = port; e[65] = blk;
      return e;
   endfunction

   function automatic logic [EW-1:0] mk_mc(input logic [47:0] mac, input logic [2:0] msk);
      logic [EW-1:0] e = '0;
      e[61:60] = 2'd1; e[47:0] = mac; e[68:66] = msk;
      return e;
   endfunction

   function automatic logic [NP-1:0] fwd_set();
      logic [NP-1:0] f;
      for (int p = 0; p < NP; p++) f[p] = (m_ps[p] == 2'd3);
      return f;
   endfunction

   function automatic logic [NP-1:0] exp_mask(input logic [47:0] mac, input logic [1:0] ing);
      logic [NP-1:0] r;
      if (!m_en) return fwd_set();
      for (int i = 0; i < NE; i++) begin
         if ((m_ent[i][61:60] == 2'd1 || m_ent[i][61:60] == 2'd3) && m_ent[i][47:0] == mac) begin
            if (m_ent[i][40]) r = m_ent[i][68:66];
            else if (m_ent[i][65]) r = '0;
            else begin
               r = '0;
               for (int p = 0; p < NP; p++) if (m_ent[i][67:66] == 2'(p)) r[p] = 1'b1;
            end
            return r & fwd_set();
         end
      end
      r = '1;
      for (int p = 0; p < NP; p++) if (ing == 2'(p)) r[p] = 1'b0;
      return r & fwd_set();
   endfunction

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   localparam logic [47:0] MA = 48'h0A1B_2C3D_4E00;
   localparam logic [47:0] MB = 48'h0A1B_2C3D_4E01;
   localparam logic [47:0] MC = 48'h021B_2C3D_4E02;
   localparam logic [47:0] MD = 48'h0A1B_2C3D_4E03;
   localparam logic [47:0] MM = 48'h0100_5E00_0001;

   initial begin
      logic [31:0] d;
      logic [EW-1:0] e;
      logic [NP-1:0] m;
      int cnt, ndone;
      logic [47:0] pool [4];
      void'($urandom(32'd20240611));
      pool[0] = MA; pool[1] = MB; pool[2] = MM; pool[3] = 48'h0133_0000_00FF;
      for (int i = 0; i < NE; i++) m_ent[i] = '0;
      for (int p = 0; p < NP; p++) m_ps[p] = 2'd0;
      m_en = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(4'd0, d); check(d == 0, "R10 ctrl", EW'(d), 0);
      rd(4'd9, d); check(d == 0, "R10 port state", EW'(d), 0);
      check(lk_busy == 1'b0, "R10 busy", EW'(lk_busy), 0);
      get_entry(3, e); check(e == '0, "R10 entry free", e, 0);

      // R8 control readback
      wr(4'd0, 32'h8000_0004); m_en = 1'b1;
      rd(4'd0, d); check(d == 32'h8000_0004, "R8 ctrl readback", EW'(d), EW'(32'h8000_0004));
      for (int p = 0; p < NP; p++) set_ps(p, 2'd3);

      // R1 indirect write / read
      e = {5'h15, 32'hA5A5_5A5A, 32'h1234_5678};
      put_entry(5, e);
      get_entry(5, e);
      check(e == {5'h15, 32'hA5A5_5A5A, 32'h1234_5678}, "R1 entry readback", e, {5'h15, 32'hA5A5_5A5A, 32'h1234_5678});
      rd(4'd1, d); check(d == 5, "R1 index readback", EW'(d), 5);

      // R8 wipe
      wr(4'd0, 32'hC000_0000);
      for (int i = 0; i < NE; i++) m_ent[i] = '0;
      rd(4'd0, d); check(d == 32'h8000_0000, "R8 wipe bit self-clears", EW'(d), EW'(32'h8000_0000));
      get_entry(5, e); check(e == '0, "R8 wipe frees entry", e, 0);

      // directed table
      put_entry(0, mk_uc(2'd2, MA, 2'd2, 1'b0));
      put_entry(1, mk_uc(2'd1, MA, 2'd1, 1'b0));
      put_entry(2, mk_uc(2'd1, MA, 2'd2, 1'b0));
      put_entry(3, mk_uc(2'd1, MB, 2'd0, 1'b1));
      put_entry(4, mk_mc(MM, 3'b101));
      put_entry(5, mk_uc(2'd3, MC, 2'd0, 1'b0));
      put_entry(6, mk_uc(2'd0, MD, 2'd2, 1'b0));

      do_lookup(MA, 2'd0, m, cnt);
      check(m == 3'b010, "R3 first match / R2 vlan skipped", EW'(m), EW'(3'b010));
      check(cnt == 2, "R9 hit latency", EW'(cnt), 2);
      @(negedge clk);
      check(lk_done == 1'b0, "R9 done single pulse", EW'(lk_done), 0);
      do_lookup(MB, 2'd1, m, cnt);
      check(m == 3'b000, "R4 blocked unicast", EW'(m), 0);
      do_lookup(MM, 2'd0, m, cnt);
      check(m == 3'b101, "R5 multicast mask", EW'(m), EW'(3'b101));
      do_lookup(MC, 2'd2, m, cnt);
      check(m == 3'b001, "R2 vlan+address type matches", EW'(m), EW'(3'b001));
      do_lookup(MD, 2'd1, m, cnt);
      check(m == 3'b101, "R6 miss floods except ingress", EW'(m), EW'(3'b101));
      check(cnt == NE, "R9 miss latency", EW'(cnt), NE);

      // R7 port states
      set_ps(1, 2'd2);
      do_lookup(MD, 2'd0, m, cnt);
      check(m == 3'b100, "R7 learning port excluded", EW'(m), EW'(3'b100));
      do_lookup(MA, 2'd0, m, cnt);
      check(m == 3'b000, "R7 unicast to non-forwarding port", EW'(m), 0);
      rd(4'd9, d); check(d == 2, "R7 port state readback", EW'(d), 2);

      // R8 disabled engine
      wr(4'd0, 32'h0); m_en = 1'b0;
      do_lookup(MB, 2'd0, m, cnt);
      check(m == 3'b101, "R8 disabled floods forwarding ports", EW'(m), EW'(3'b101));
      check(cnt == 1, "R9 disabled latency", EW'(cnt), 1);
      wr(4'd0, 32'h8000_0000); m_en = 1'b1;
      set_ps(1, 2'd3);

      // R9 start while busy ignored
      @(negedge clk); lk_mac = MD; lk_ingress = 2'd2; lk_start = 1'b1;
      @(negedge clk); lk_start = 1'b0;
      @(negedge clk);
      check(lk_busy == 1'b1, "R9 busy during scan", EW'(lk_busy), 1);
      lk_mac = MA; lk_ingress = 2'd0; lk_start = 1'b1;
      @(negedge clk); lk_start = 1'b0;
      ndone = 0; m = '0;
      for (int k = 0; k < 2 * NE + 4; k++) begin
         if (lk_done) begin ndone++; m = lk_mask; end
         @(negedge clk);
      end
      check(ndone == 1, "R9 restart while busy ignored", EW'(ndone), 1);
      check(m == 3'b011, "R9 result belongs to first start", EW'(m), EW'(3'b011));

      // randomized rounds
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < NE; i++) begin
            e = {$urandom, $urandom, $urandom};
            e[47:0] = pool[$urandom % 4];
            put_entry(i, e);
         end
         for (int p = 0; p < NP; p++) set_ps(p, 2'($urandom % 4));
         m_en = ($urandom % 8) != 0;
         wr(4'd0, m_en ? 32'h8000_0000 : 32'h0);
         for (int l = 0; l < 8; l++) begin
            logic [47:0] mac;
            logic [1:0] ing;
            mac = ($urandom % 5 == 0) ? MD : pool[$urandom % 4];
            ing = 2'($urandom % 3);
            do_lookup(mac, ing, m, cnt);
            check(m == exp_mask(mac, ing), "R3 random lookup", EW'(m), EW'(exp_mask(mac, ing)));
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule